// File: doc/BRIEF.md
# Motion Wakeup Detector

This block watches a stream of signed 8-bit acceleration samples on three axes and decides when the part has been moved. It reacts to the change between one sample and the one before, not to the absolute reading. A steady tilt under gravity therefore never wakes the system, but a jolt does.

For each axis, each direction has its own enable. A change counts in a direction when it is larger than the programmed threshold in that direction and the direction is enabled. Such changes must continue for a programmed number of consecutive samples before the block reports anything. It then gives a single-cycle event pulse and a six-bit direction word that says which axis senses caused the final qualifying sample. The threshold is in the same counts as the samples, 16 counts per g for the 8-bit data, so the usual setting of 8 is half a g. Samples arrive at a wakeup rate produced elsewhere, and each one is marked by a one-cycle valid strobe.

A three-state sequencer controls the engine. OFF is the state while the engine is disabled. PRIME waits for the first sample after enable and only records it. TRACK compares every later sample with the one stored before it. Transitions: OFF to PRIME when enable rises. PRIME to TRACK on the first valid sample. PRIME or TRACK back to OFF whenever enable drops.

Top module: `wk_motion_detect`

## Requirements
- R1: After reset, `wake_pulse` is 0 and `wake_dir` is 0.
- R2: The first valid sample after the engine is enabled only records the sample and never produces an event, however large its step from earlier data.
- R3: The change is the current sample minus the previous sample, computed without wrap-around. A step from -128 to 127 is +255.
- R4: A direction qualifies only when the change is strictly greater than `wake_thr`, or strictly less than minus `wake_thr`. A change equal to the threshold does not qualify.
- R5: A positive change sets the plus bit and a negative change sets the minus bit. The bit positions in `wake_dir` are X- bit 5, X+ bit 4, Y- bit 3, Y+ bit 2, Z- bit 1, Z+ bit 0.
- R6: `dir_en` uses the same bit positions as `wake_dir`. A direction whose enable bit is 0 neither counts toward persistence nor appears in `wake_dir`.
- R7: An event fires on the Nth consecutive valid sample with at least one qualifying enabled direction, where N is `wake_persist`. Any valid sample without one restarts the count.
- R8: A `wake_persist` of 0 behaves as 1.
- R9: After an event, the count starts again from zero, so a further N qualifying samples are needed for the next event.
- R10: `wake_pulse` is high for exactly the one clock cycle after the edge that takes the deciding sample. On that same edge, `wake_dir` loads the enabled qualifying directions of that sample and then holds them until the next event or until the engine is disabled.
- R11: While `wake_en` is 0, no event fires and `wake_dir` reads 0. Samples that arrive while disabled are ignored. After re-enable, the engine must prime again.
- R12: Sample inputs are ignored on cycles where `smp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_en | input | 1 | Engine enable |
| smp_valid | input | 1 | One-cycle strobe marking a new sample set |
| smp_x | input | 8 | X sample, two's complement |
| smp_y | input | 8 | Y sample, two's complement |
| smp_z | input | 8 | Z sample, two's complement |
| wake_thr | input | 8 | Unsigned change threshold in counts |
| wake_persist | input | 8 | Consecutive qualifying samples needed (0 behaves as 1) |
| dir_en | input | 6 | Per-direction enables, positions as in R5 |
| wake_pulse | output | 1 | Single-cycle wakeup event |
| wake_dir | output | 6 | Directions of the last event, held |

## Verification
The assertions assume the following about the inputs:
- `smp_valid` is never high on two adjacent cycles, as is true of any wakeup rate far below the clock.
- `wake_en`, `dir_en`, `wake_thr` and `wake_persist` change only between samples.

The stimulus keeps to these assumptions. Every sample is a one-cycle strobe followed by at least one idle cycle. Configuration inputs are changed on a falling clock edge while no strobe is pending. Under these conditions, a pulse can be traced back one cycle to a strobe, to the TRACK state and to the enables in force at that moment.

// File: rtl/wk_pkg.sv
package wk_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_PRIME = 2'd1,
        ST_TRACK = 2'd2
    } wk_state_e;

    localparam int WK_AXES = 3;
    localparam int WK_DIRS = 2 * WK_AXES;

endpackage

// File: rtl/wk_axis_delta.sv
module wk_axis_delta #(
    parameter int SMP_W = 8,
    parameter int THR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic signed [SMP_W-1:0] cur,
    input  logic        [THR_W-1:0] thr,
    output logic                    pos_hit,
    output logic                    neg_hit
);
    localparam int DIFF_W = SMP_W + 1;
    localparam int CMP_W  = ((DIFF_W > THR_W + 1) ? DIFF_W : THR_W + 1) + 1;

    logic signed [SMP_W-1:0] prev_q;
    logic signed [CMP_W-1:0] cur_ext;
    logic signed [CMP_W-1:0] prev_ext;
    logic signed [CMP_W-1:0] delta;
    logic signed [CMP_W-1:0] thr_ext;
    logic signed [CMP_W-1:0] thr_neg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else if (load) begin
            prev_q <= cur;
        end
    end

    always_comb begin
        cur_ext  = {{(CMP_W-SMP_W){cur[SMP_W-1]}}, cur};
        prev_ext = {{(CMP_W-SMP_W){prev_q[SMP_W-1]}}, prev_q};
        delta    = cur_ext - prev_ext;
        thr_ext  = {{(CMP_W-THR_W){1'b0}}, thr};
        thr_neg  = -thr_ext;
        pos_hit  = (delta > thr_ext);
        neg_hit  = (delta < thr_neg);
    end

endmodule

// File: rtl/wk_persist.sv
module wk_persist #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             hit,
    input  logic [CNT_W-1:0] limit,
    output logic             fire
);
    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] cnt_q;
    logic [EXT_W-1:0] cnt_nxt;
    logic [EXT_W-1:0] eff_limit;

    always_comb begin
        eff_limit = (limit == '0) ? EXT_W'(1) : {1'b0, limit};
        cnt_nxt   = cnt_q + EXT_W'(1);
        fire      = step && hit && (cnt_nxt >= eff_limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            if (!hit || fire) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_nxt;
            end
        end
    end

endmodule

// File: rtl/wk_motion_detect.sv
module wk_motion_detect
    import wk_pkg::*;
#(
    parameter int SMP_W = 8,
    parameter int THR_W = 8,
    parameter int CNT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wake_en,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_x,
    input  logic signed [SMP_W-1:0] smp_y,
    input  logic signed [SMP_W-1:0] smp_z,
    input  logic        [THR_W-1:0] wake_thr,
    input  logic        [CNT_W-1:0] wake_persist,
    input  logic        [WK_DIRS-1:0] dir_en,
    output logic                    wake_pulse,
    output logic        [WK_DIRS-1:0] wake_dir
);

    wk_state_e state_q;
    wk_state_e state_nxt;

    logic signed [SMP_W-1:0] smp_arr [WK_AXES];
    logic [WK_DIRS-1:0] raw_hits;
    logic [WK_DIRS-1:0] qual_hits;
    logic               any_hit;
    logic               load_prev;
    logic               score;
    logic               fire;

    assign smp_arr[0] = smp_x;
    assign smp_arr[1] = smp_y;
    assign smp_arr[2] = smp_z;

    always_comb begin
        load_prev = wake_en && smp_valid &&
                    ((state_q == ST_PRIME) || (state_q == ST_TRACK));
        score     = wake_en && smp_valid && (state_q == ST_TRACK);
    end

    // one delta unit per axis; axis a drives minus bit 2*(AXES-1-a)+1 and plus bit 2*(AXES-1-a)
    for (genvar a = 0; a < WK_AXES; a++) begin : g_axis
        localparam int PBIT = 2 * (WK_AXES - 1 - a);
        wk_axis_delta #(
            .SMP_W (SMP_W),
            .THR_W (THR_W)
        ) u_delta (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load_prev),
            .cur     (smp_arr[a]),
            .thr     (wake_thr),
            .pos_hit (raw_hits[PBIT]),
            .neg_hit (raw_hits[PBIT+1])
        );
    end

    always_comb begin
        qual_hits = raw_hits & dir_en;
        any_hit   = |qual_hits;
    end

    wk_persist #(
        .CNT_W (CNT_W)
    ) u_persist (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != ST_TRACK),
        .step  (score),
        .hit   (any_hit),
        .limit (wake_persist),
        .fire  (fire)
    );

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_OFF:   if (wake_en) state_nxt = ST_PRIME;
            ST_PRIME: begin
                if (!wake_en)       state_nxt = ST_OFF;
                else if (smp_valid) state_nxt = ST_TRACK;
            end
            ST_TRACK: if (!wake_en) state_nxt = ST_OFF;
            default:  state_nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_pulse <= 1'b0;
            wake_dir   <= '0;
        end else begin
            wake_pulse <= fire;
            if (!wake_en) begin
                wake_dir <= '0;
            end else if (fire) begin
                wake_dir <= qual_hits;
            end
        end
    end

endmodule

// File: rtl/wk_motion_detect_chk.sv
module wk_motion_detect_chk
    import wk_pkg::*;
#(
    parameter int DIRS = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wake_en,
    input logic            smp_valid,
    input logic [DIRS-1:0] dir_en,
    input logic            wake_pulse,
    input logic [DIRS-1:0] wake_dir,
    input wk_state_e       state_q
);

    // R2
    primed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> ($past(state_q) == ST_TRACK));

    // R12
    valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(smp_valid));

    // R5
    dir_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (wake_dir != '0));

    // R6
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> ((wake_dir & ~$past(dir_en)) == '0));

    // R11
    flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_en |=> (wake_dir == '0));

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_pulse && $past(wake_en)) |-> $stable(wake_dir));

endmodule

bind wk_motion_detect wk_motion_detect_chk #(
    .DIRS (wk_pkg::WK_DIRS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake_en    (wake_en),
    .smp_valid  (smp_valid),
    .dir_en     (dir_en),
    .wake_pulse (wake_pulse),
    .wake_dir   (wake_dir),
    .state_q    (state_q)
);

// File: tb/wk_motion_detect_bench.sv
`timescale 1ns/1ps
module wk_motion_detect_bench;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wake_en = 1'b0;
    logic              smp_valid = 1'b0;
    logic signed [7:0] smp_x = '0;
    logic signed [7:0] smp_y = '0;
    logic signed [7:0] smp_z = '0;
    logic        [7:0] wake_thr = 8'd8;
    logic        [7:0] wake_persist = 8'd1;
    logic        [5:0] dir_en = 6'h3F;
    logic              wake_pulse;
    logic        [5:0] wake_dir;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wk_motion_detect u_wk_motion_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .wake_en      (wake_en),
        .smp_valid    (smp_valid),
        .smp_x        (smp_x),
        .smp_y        (smp_y),
        .smp_z        (smp_z),
        .wake_thr     (wake_thr),
        .wake_persist (wake_persist),
        .dir_en       (dir_en),
        .wake_pulse   (wake_pulse),
        .wake_dir     (wake_dir)
    );

    task automatic check(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive one strobed sample, then look at the outputs after the capturing edge
    task automatic send(input logic signed [7:0] x, input logic signed [7:0] y,
                        input logic signed [7:0] z, input logic exp_p,
                        input logic [5:0] exp_f, input string req);
        @(negedge clk);
        smp_x = x; smp_y = y; smp_z = z;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        check(int'(wake_pulse), int'(exp_p), req, "pulse");
        check(int'(wake_dir), int'(exp_f), req, "dir");
        @(negedge clk);
        check(int'(wake_pulse), 0, "R10", "pulse width");
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(int'(wake_pulse), 0, "R1", "reset pulse");
        check(int'(wake_dir), 0, "R1", "reset dir");
    endtask

    task automatic t_prime();
        wake_en = 1'b1;
        send(100, 0, 0, 0, 6'h00, "R2");
        send(100, 0, 0, 0, 6'h00, "R2");
        send(120, 0, 0, 1, 6'b010000, "R5");
    endtask

    task automatic t_thresh();
        send(112, 0, 0, 0, 6'b010000, "R4");
        send(103, 0, 0, 1, 6'b100000, "R4");
    endtask

    task automatic t_wide();
        wake_thr = 8'd254;
        send(-128, 0, 0, 0, 6'b100000, "R3");
        send(127, 0, 0, 1, 6'b010000, "R3");
        wake_thr = 8'd8;
    endtask

    task automatic t_mask();
        dir_en = 6'b111011;
        send(127, 50, 0, 0, 6'b010000, "R6");
        send(127, 0, -40, 1, 6'b001010, "R6");
        dir_en = 6'h3F;
    endtask

    task automatic t_persist();
        wake_persist = 8'd3;
        send(127, 20, -40, 0, 6'b001010, "R7");
        send(127, 40, -40, 0, 6'b001010, "R7");
        send(127, 40, -40, 0, 6'b001010, "R7");
        send(127, 60, -40, 0, 6'b001010, "R7");
        send(127, 80, -40, 0, 6'b001010, "R7");
        send(127, 100, -40, 1, 6'b000100, "R7");
        send(127, 120, -40, 0, 6'b000100, "R9");
        send(127, -10, -40, 0, 6'b000100, "R9");
        send(127, -30, -40, 1, 6'b001000, "R9");
    endtask

    task automatic t_zero();
        wake_persist = 8'd0;
        send(127, -30, -40, 0, 6'b001000, "R8");
        send(127, -30, 0, 1, 6'b000001, "R8");
        wake_persist = 8'd1;
    endtask

    task automatic t_novalid();
        @(negedge clk);
        smp_x = -100; smp_y = 90; smp_z = -90;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(int'(wake_pulse), 0, "R12", "no strobe pulse");
        end
        send(127, -30, 0, 0, 6'b000001, "R12");
    endtask

    task automatic t_disable();
        @(negedge clk);
        wake_en = 1'b0;
        @(negedge clk);
        check(int'(wake_dir), 0, "R11", "dir cleared");
        send(0, 0, 0, 0, 6'h00, "R11");
        wake_en = 1'b1;
        send(-100, 0, 0, 0, 6'h00, "R11");
        send(-80, 0, 0, 1, 6'b010000, "R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_prime();
        t_thresh();
        t_wide();
        t_mask();
        t_persist();
        t_zero();
        t_novalid();
        t_disable();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule